// File: doc/BRIEF.md
# RGB Panel Timing Generator

This block produces the dot clock, line sync, frame sync, data-enable and 24-bit data bus for an active-matrix panel with a 480 by 272 visible area. Pixels arrive on a ready/valid port as 24-bit words packed red in bits 23:16, green in 15:8 and blue in 7:0. Each pixel is either sent whole on one dot (parallel mode) or sent as three byte-wide beats on the lowest lane (serial mode).

The dot clock runs at half the system clock. Each dot lasts two system cycles. Every output except the clock pin itself changes only at the system edge that ends a dot. A line is laid out as active area, front porch, sync pulse and back porch. A frame is laid out the same way in lines. All of these lengths are parameters. In serial mode every horizontal length is counted in beats, which is three times the pixel count. The sync polarities and the dot clock edge that the panel samples on are static configuration inputs. The transfer mode is sampled once per frame.

Top module: `rgb_panel_timing`

## Requirements
- R1: While reset is low: `de_o`, `bus_o`, `pix_ready_o` and `underflow_o` are 0, and both syncs are at their inactive level. After reset the block is in parallel mode, and its first dot is the first active dot of a frame.
- R2: Every line that has active dots has H_ACT×k dots with `de_o` high. Every frame has V_ACT such lines. Lines recur every (H_ACT+H_FP+H_SW+H_BP)×k dots. Here k is 1 in parallel mode and 3 in serial mode.
- R3: The line sync is active for H_SW×k dots and starts (H_ACT+H_FP)×k dots into a line. The frame sync is active for V_SW lines, starting V_ACT+V_FP lines into a frame.
- R4: With `hs_pol_i`=1 the line sync is active high. With `hs_pol_i`=0 it is active low. `vs_pol_i` does the same for the frame sync.
- R5: With `dclk_fall_i`=0 the outputs change while `dclk_o` falls, so the panel samples them on the rising edge. With `dclk_fall_i`=1 the outputs change while `dclk_o` rises.
- R6: In parallel mode each active dot carries one pixel: red on `bus_o[7:0]`, green on `bus_o[15:8]`, blue on `bus_o[23:16]`.
- R7: In serial mode each pixel takes three consecutive active dots. The first carries red on `bus_o[7:0]`, the second green, the third blue. `bus_o[23:8]` stays 0 throughout.
- R8: Whenever `de_o` is low, `bus_o` is 0 (black).
- R9: `pix_ready_o` is high for exactly one system cycle at the start of each active pixel slot, and never at any other time. The word offered in that cycle is the one shown in that slot. Exactly H_ACT×V_ACT pixels are taken per frame.
- R10: If `pix_valid_i` is low while `pix_ready_o` is high, that pixel is shown as black. `underflow_o` is high for the first dot of that pixel.
- R11: `serial_mode_i` is sampled only where the frame sync becomes active. A change in the middle of a frame does not alter that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, twice the dot rate |
| rst_n | input | 1 | Active-low synchronous reset |
| serial_mode_i | input | 1 | 1 = three-beat byte mode, 0 = one-dot parallel mode |
| hs_pol_i | input | 1 | Line sync active level |
| vs_pol_i | input | 1 | Frame sync active level |
| dclk_fall_i | input | 1 | 1 = panel samples on the falling dot clock edge |
| pix_data_i | input | 24 | Pixel word {R,G,B} |
| pix_valid_i | input | 1 | Pixel word present |
| pix_ready_o | output | 1 | Pixel taken in this cycle |
| dclk_o | output | 1 | Dot clock |
| hsync_o | output | 1 | Line sync |
| vsync_o | output | 1 | Frame sync |
| de_o | output | 1 | Active-data enable |
| bus_o | output | 24 | Panel data bus |
| underflow_o | output | 1 | Starved pixel marker |

## Verification
`pix_ready_o` is high in the system cycle just before the edge that launches the pixel's first dot. The bench therefore drives the word at the falling system edge inside that cycle. Every other result appears at the launching edge and holds for two system cycles. The monitor recognises a new dot at the first falling system edge where `dclk_o` is at its launch level, and samples all outputs there. It pops one expected beat from the scoreboard queue for each dot with `de_o` high. Sync widths and line periods are measured in dots counted the same way. Whenever the bus changes, the bench also checks `dclk_o` at that falling edge to confirm that the data launch edge was selected correctly.

// File: rtl/rgb_panel_timing.sv
module rgb_panel_timing #(
  parameter int H_ACT = 480,
  parameter int H_FP  = 8,
  parameter int H_SW  = 41,
  parameter int H_BP  = 2,
  parameter int V_ACT = 272,
  parameter int V_FP  = 2,
  parameter int V_SW  = 10,
  parameter int V_BP  = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        serial_mode_i,
  input  logic        hs_pol_i,
  input  logic        vs_pol_i,
  input  logic        dclk_fall_i,
  input  logic [23:0] pix_data_i,
  input  logic        pix_valid_i,
  output logic        pix_ready_o,
  output logic        dclk_o,
  output logic        hsync_o,
  output logic        vsync_o,
  output logic        de_o,
  output logic [23:0] bus_o,
  output logic        underflow_o
);

  localparam int H_TOT = H_ACT + H_FP + H_SW + H_BP;
  localparam int V_TOT = V_ACT + V_FP + V_SW + V_BP;
  localparam int HW = $clog2(3 * H_TOT);
  localparam int VW = $clog2(V_TOT);

  localparam logic [HW-1:0] P_ACT = HW'(H_ACT);
  localparam logic [HW-1:0] P_SS  = HW'(H_ACT + H_FP);
  localparam logic [HW-1:0] P_SE  = HW'(H_ACT + H_FP + H_SW);
  localparam logic [HW-1:0] P_END = HW'(H_TOT - 1);
  localparam logic [HW-1:0] S_ACT = HW'(3 * H_ACT);
  localparam logic [HW-1:0] S_SS  = HW'(3 * (H_ACT + H_FP));
  localparam logic [HW-1:0] S_SE  = HW'(3 * (H_ACT + H_FP + H_SW));
  localparam logic [HW-1:0] S_END = HW'(3 * H_TOT - 1);

  localparam logic [VW-1:0] L_ACT = VW'(V_ACT);
  localparam logic [VW-1:0] L_PRE = VW'(V_ACT + V_FP - 1);
  localparam logic [VW-1:0] L_SS  = VW'(V_ACT + V_FP);
  localparam logic [VW-1:0] L_SE  = VW'(V_ACT + V_FP + V_SW);
  localparam logic [VW-1:0] L_END = VW'(V_TOT - 1);

  logic          ph;
  logic          serial_q;
  logic [HW-1:0] h;
  logic [VW-1:0] v;
  logic [1:0]    beat;
  logic          de_q, hs_q, vs_q, uf_q;
  logic [23:0]   bus_q, px_q;

  logic          h_last, mode_n, de_n, hs_n, vs_n, open_n;
  logic [HW-1:0] h_n;
  logic [VW-1:0] v_n;
  logic [1:0]    beat_n;
  logic [23:0]   fetched, cur, bus_n;
  logic [7:0]    lane;

  assign h_last = h == (serial_q ? S_END : P_END);
  assign h_n    = h_last ? '0 : h + 1'b1;
  assign v_n    = !h_last ? v : (v == L_END) ? '0 : v + 1'b1;
  assign mode_n = (h_last && v == L_PRE) ? serial_mode_i : serial_q;
  assign beat_n = (!mode_n || h_last || beat == 2'd2) ? 2'd0 : beat + 2'd1;

  assign de_n = (h_n < (mode_n ? S_ACT : P_ACT)) && (v_n < L_ACT);
  assign hs_n = (h_n >= (mode_n ? S_SS : P_SS)) && (h_n < (mode_n ? S_SE : P_SE));
  assign vs_n = (v_n >= L_SS) && (v_n < L_SE);

  assign open_n      = de_n && beat_n == 2'd0;
  assign pix_ready_o = ph && open_n;

  assign fetched = pix_valid_i ? pix_data_i : 24'd0;
  assign cur     = open_n ? fetched : px_q;

  always_comb begin
    case (beat_n)
      2'd0:    lane = cur[23:16];
      2'd1:    lane = cur[15:8];
      default: lane = cur[7:0];
    endcase
    if (!de_n)       bus_n = '0;
    else if (mode_n) bus_n = {16'd0, lane};
    else             bus_n = {cur[7:0], cur[15:8], cur[23:16]};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph       <= 1'b0;
      serial_q <= 1'b0;
      h        <= P_END;
      v        <= L_END;
      beat     <= 2'd0;
      de_q     <= 1'b0;
      hs_q     <= 1'b0;
      vs_q     <= 1'b0;
      uf_q     <= 1'b0;
      bus_q    <= '0;
      px_q     <= '0;
    end else begin
      ph <= ~ph;
      if (ph) begin
        serial_q <= mode_n;
        h        <= h_n;
        v        <= v_n;
        beat     <= beat_n;
        de_q     <= de_n;
        hs_q     <= hs_n;
        vs_q     <= vs_n;
        uf_q     <= open_n && !pix_valid_i;
        bus_q    <= bus_n;
        px_q     <= cur;
      end
    end
  end

  assign dclk_o      = dclk_fall_i ? ~ph : ph;
  assign hsync_o     = hs_pol_i ? hs_q : ~hs_q;
  assign vsync_o     = vs_pol_i ? vs_q : ~vs_q;
  assign de_o        = de_q;
  assign bus_o       = bus_q;
  assign underflow_o = uf_q;

endmodule

// File: rtl/rgb_panel_timing_chk.sv
module rgb_panel_timing_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        ph,
  input logic        serial_q,
  input logic        vs_q,
  input logic        de_o,
  input logic [23:0] bus_o,
  input logic        pix_ready_o,
  input logic        underflow_o
);

  assert_blank_black_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !de_o |-> bus_o == 24'd0);

  assert_serial_upper_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    serial_q |-> bus_o[23:8] == 16'd0);

  assert_ready_opens_slot_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pix_ready_o |=> de_o);

  assert_ready_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pix_ready_o |=> !pix_ready_o);

  assert_underflow_black_R10: assert property (@(posedge clk) disable iff (!rst_n)
    underflow_o |-> (de_o && bus_o == 24'd0));

  assert_mode_at_frame_sync_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(serial_q) |-> $rose(vs_q));

  assert_dot_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(bus_o) |-> $past(ph));

endmodule

bind rgb_panel_timing rgb_panel_timing_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ph(ph), .serial_q(serial_q), .vs_q(vs_q),
  .de_o(de_o), .bus_o(bus_o), .pix_ready_o(pix_ready_o), .underflow_o(underflow_o)
);

// File: tb/rgb_panel_timing_test.sv
module rgb_panel_timing_test;
  localparam int HA = 4, HF = 2, HS = 3, HB = 1;
  localparam int VA = 3, VF = 1, VS = 2, VB = 1;
  localparam int HT = HA + HF + HS + HB;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic serial_mode_i = 1'b0, hs_pol_i = 1'b0, vs_pol_i = 1'b0, dclk_fall_i = 1'b0;
  logic [23:0] pix_data_i = '0;
  logic pix_valid_i = 1'b0;
  logic pix_ready_o, dclk_o, hsync_o, vsync_o, de_o, underflow_o;
  logic [23:0] bus_o;

  always #10 clk = ~clk;

  rgb_panel_timing #(.H_ACT(HA), .H_FP(HF), .H_SW(HS), .H_BP(HB),
                     .V_ACT(VA), .V_FP(VF), .V_SW(VS), .V_BP(VB)) uut (
    .clk(clk), .rst_n(rst_n), .serial_mode_i(serial_mode_i), .hs_pol_i(hs_pol_i),
    .vs_pol_i(vs_pol_i), .dclk_fall_i(dclk_fall_i), .pix_data_i(pix_data_i),
    .pix_valid_i(pix_valid_i), .pix_ready_o(pix_ready_o), .dclk_o(dclk_o),
    .hsync_o(hsync_o), .vsync_o(vsync_o), .de_o(de_o), .bus_o(bus_o),
    .underflow_o(underflow_o));

  typedef struct packed { logic [23:0] bus; logic uf; } beat_t;
  beat_t exp_q[$];

  int total = 0, bad = 0;
  int pix_idx, pix_at_vs, starve_a, starve_b, switch_at;
  int frames, dots, de_cnt, hs_w, vlines, de_lines, bpp;
  bit exp_serial, skip_period, hs_prev, vs_prev, prev_dclk, hs_a, vs_a;
  logic [23:0] prev_bus;
  beat_t got;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  function automatic logic [23:0] pat(input int k);
    return {8'(k * 37 + 17), 8'(k * 11 + 90), 8'(k * 5 + 200)};
  endfunction

  // driver: offers a word when a slot opens and pushes the beats it must produce
  always @(negedge clk) begin
    if (rst_n && pix_ready_o) begin
      logic [23:0] p;
      bit starve;
      starve = (pix_idx == starve_a) || (pix_idx == starve_b);
      p = pat(pix_idx);
      pix_valid_i = !starve;
      pix_data_i  = starve ? 24'hA5A5A5 : p;
      if (starve) p = 24'd0;
      if (exp_serial) begin
        exp_q.push_back('{bus: {16'd0, p[23:16]}, uf: starve});
        exp_q.push_back('{bus: {16'd0, p[15:8]},  uf: 1'b0});
        exp_q.push_back('{bus: {16'd0, p[7:0]},   uf: 1'b0});
      end else begin
        exp_q.push_back('{bus: {p[7:0], p[15:8], p[23:16]}, uf: starve});
      end
      pix_idx++;
      if (pix_idx == switch_at) serial_mode_i = 1'b1;
    end
  end

  // monitor: one sample per dot, taken once dclk_o sits at its launch level
  always @(negedge clk) begin
    if (rst_n) begin
      if (bus_o != prev_bus)
        check(dclk_o == dclk_fall_i, "R5", "dclk level at data change", dclk_o, dclk_fall_i);
      if (dclk_o == dclk_fall_i && prev_dclk != dclk_fall_i) begin
        hs_a = hs_pol_i ? hsync_o : ~hsync_o;
        vs_a = vs_pol_i ? vsync_o : ~vsync_o;
        if (vs_a && !vs_prev) begin
          check(de_lines == VA, "R2", "active lines per frame", de_lines, VA);
          check(pix_idx - pix_at_vs == HA * VA, "R9", "pixels taken per frame",
                pix_idx - pix_at_vs, HA * VA);
          pix_at_vs = pix_idx;
          de_lines = 0;
          vlines = 0;
          exp_serial = serial_mode_i;
          skip_period = 1'b1;
          frames++;
        end
        bpp = exp_serial ? 3 : 1;
        if (!vs_a && vs_prev)
          check(vlines == VS, "R3", "frame sync lines", vlines, VS);
        if (hs_a && !hs_prev) begin
          if (!skip_period)
            check(dots == HT * bpp, "R2", "line period in dots", dots, HT * bpp);
          skip_period = 1'b0;
          if (de_cnt != 0) begin
            check(de_cnt == HA * bpp, (serial_mode_i != exp_serial) ? "R11" : "R2",
                  "active dots per line", de_cnt, HA * bpp);
            de_lines++;
          end
          if (vs_a) vlines++;
          dots = 0;
          de_cnt = 0;
          hs_w = 0;
        end
        if (!hs_a && hs_prev)
          check(hs_w == HS * bpp, "R3", "line sync width", hs_w, HS * bpp);
        if (hs_a) hs_w++;
        dots++;
        if (de_o) begin
          de_cnt++;
          if (exp_q.size() == 0) begin
            check(1'b0, "R9", "active dot without a taken pixel", bus_o, 0);
          end else begin
            got = exp_q.pop_front();
            check(bus_o == got.bus, exp_serial ? "R7" : "R6", "bus beat", bus_o, got.bus);
            check(underflow_o == got.uf, "R10", "underflow flag", underflow_o, got.uf);
          end
        end else begin
          check(bus_o == 24'd0, "R8", "bus while blanked", bus_o, 0);
        end
        hs_prev = hs_a;
        vs_prev = vs_a;
      end
    end
    prev_dclk = dclk_o;
    prev_bus  = bus_o;
  end

  task automatic run(input bit pol, input bit fall, input bit ser0, input int sw,
                     input int sa, input int sb, input int nframes);
    int cyc;
    rst_n = 1'b0;
    hs_pol_i = pol; vs_pol_i = pol; dclk_fall_i = fall;
    serial_mode_i = ser0; pix_valid_i = 1'b0;
    switch_at = sw; starve_a = sa; starve_b = sb;
    pix_idx = 0; pix_at_vs = 0; frames = 0; dots = 0; de_cnt = 0; hs_w = 0;
    vlines = 0; de_lines = 0; exp_serial = 1'b0; skip_period = 1'b1;
    hs_prev = 1'b0; vs_prev = 1'b0;
    exp_q.delete();
    repeat (4) @(negedge clk);
    check(de_o == 1'b0 && bus_o == 24'd0, "R1", "de/bus in reset", {de_o, bus_o}, 0);
    check(pix_ready_o == 1'b0 && underflow_o == 1'b0, "R1", "ready/underflow in reset",
          {pix_ready_o, underflow_o}, 0);
    check(hsync_o == ~pol, "R4", "idle line sync level", hsync_o, ~pol);
    check(vsync_o == ~pol, "R4", "idle frame sync level", vsync_o, ~pol);
    rst_n = 1'b1;
    cyc = 0;
    while (frames < nframes && cyc < 20000) begin
      @(negedge clk);
      cyc++;
    end
    check(cyc < 20000, "R2", "watchdog: frame syncs seen", frames, nframes);
    check(exp_q.size() == 0, "R9", "beats left undelivered", exp_q.size(), 0);
  endtask

  initial begin
    prev_bus = '0;
    prev_dclk = 1'b0;
    // parallel frame with a mid-frame switch request, then serial frames
    run(1'b0, 1'b0, 1'b0, 3, 5, 16, 3);
    // inverted polarities, falling-edge sampling, serial requested from reset
    run(1'b1, 1'b1, 1'b1, -1, 12, 23, 2);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule